// File: doc/BRIEF.md
# Event Performance Counter Unit

This block watches a processor's activity and counts it. It holds three counters, all built from the same logic. Counter index 0 counts clock cycles. Counter indices 1 and 2 (event counter 0 and event counter 1) each count one single-bit event input, chosen by an 8-bit event code. The event inputs arrive as a vector, one bit per event code. A separate input carries the external trace-output event. When any counter wraps, the block raises a sticky overflow flag for it. One interrupt line combines the flags that software has enabled.

Software reaches the block through a small register port with four word addresses. The control word holds the global run bit, the counter reset strobes, the cycle divider select, the interrupt enables, the event codes and the write-one-to-clear overflow flags. Each counter also has its own address, where it can be read or loaded. There is no separate enable per counter. Software stops one event counter by selecting the trace-output code while the trace input is held low, and the other counters keep running.

The register port is single-cycle. A write takes effect at the next clock edge. Read data is a combinational function of the address and the stored state.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset all counters read 0, the overflow flags and interrupt enables are 0, the run and divider bits are 0, both event codes are 0x20, so the control word reads 0x02020000, and irq_o is low.
- R2: The word address selects the register: 0 is control, 1 is the cycle counter, 2 is event counter 0 and 3 is event counter 1. Counters read zero-extended to 32 bits. The control word fields are:
  - bit 0: run.
  - bit 1: event counter reset.
  - bit 2: cycle counter reset.
  - bit 3: divider.
  - bit 4: interrupt enable for event counter 0.
  - bit 5: interrupt enable for event counter 1.
  - bit 6: interrupt enable for the cycle counter.
  - bit 8: flag for event counter 0.
  - bit 9: flag for event counter 1.
  - bit 10: flag for the cycle counter.
  - bits 27:20: code for event counter 0.
  - bits 19:12: code for event counter 1.
  - All other bits read 0.
- R3: While the run bit is 0, no counter and no divider phase advances, whatever the event inputs do.
- R4: With run set and the divider bit clear, the cycle counter adds 1 on every clock, whatever the event codes are.
- R5: With the divider bit set, the cycle counter adds 1 once per 2^DIV_LOG2 running cycles. A write with bit 2 set also clears the divider phase.
- R6: An event counter adds 1 in a running cycle in which its selected source is high. The sources are:
  - code 0x20 selects trace_evt_i.
  - a code c below NUM_EVT with VALID_MASK[c] set selects events_i[c].
  - any other code never fires.
- R7: A control write with bit 1 set clears both event counters at that edge. A control write with bit 2 set clears the cycle counter at that edge. A clear wins over an increment in the same cycle. Bits 1 and 2 always read 0.
- R8: A write to a counter address loads the low CNT_W bits of the write data. The load wins over an increment in the same cycle and never raises a flag.
- R9: When an increment takes a counter from all-ones to zero, that counter's flag is set at the same edge and stays set until it is cleared.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as the clear leaves the flag set. Writing back the word just read keeps every configuration field unchanged.
- R11: irq_o is high exactly when some counter has both its flag and its interrupt enable set.
- R12: An event counter whose code is 0x20 holds its value while trace_evt_i is low, while the other counters keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register word address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| events_i | input | NUM_EVT | Event pulses, bit index = event code |
| trace_evt_i | input | 1 | External trace-output event (code 0x20) |
| irq_o | output | 1 | Combined overflow interrupt |

## Verification
The bench builds the block with CNT_W = 8, DIV_LOG2 = 2, NUM_EVT = 32 and the default VALID_MASK. With 8-bit counters, every counter wraps within a few hundred cycles. This makes flag setting, interrupt assertion and a wrap that lands in the same cycle as a flag clear cheap to reach. The 4-cycle divider period lets an exact divided count be checked after a short run. A behavioural model tracks every counter, flag, code and the divider phase, and it is compared with the read port and irq_o on every clock. This covers both random event patterns and directed sequences for halting, invalid codes, reset strobes and direct loads.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned SEL_W = 8;
    localparam int unsigned NCNT  = 3;

    // counter indices
    localparam int unsigned IDX_CYC = 0;
    localparam int unsigned IDX_EV0 = 1;
    localparam int unsigned IDX_EV1 = 2;

    // control word bit positions
    localparam int unsigned BIT_RUN     = 0;
    localparam int unsigned BIT_RST_EV  = 1;
    localparam int unsigned BIT_RST_CYC = 2;
    localparam int unsigned BIT_SLOW    = 3;
    localparam int unsigned SEL_A_LSB   = 20;
    localparam int unsigned SEL_B_LSB   = 12;

    // per-counter positions, indexed by counter index (cyc, ev0, ev1)
    localparam int unsigned IEN_POS [NCNT] = '{6, 4, 5};
    localparam int unsigned OVF_POS [NCNT] = '{10, 8, 9};

    localparam logic [SEL_W-1:0] CODE_TRACE = 8'h20;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CYC  = 2'd1,
        REG_EV0  = 2'd2,
        REG_EV1  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             run;
        logic             slow;
        logic [NCNT-1:0]  irq_en;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        run:    1'b0,
        slow:   1'b0,
        irq_en: '0,
        sel_a:  CODE_TRACE,
        sel_b:  CODE_TRACE
    };

endpackage

// File: rtl/pmu_event_sel.sv
`timescale 1ns/1ps
module pmu_event_sel
    import pmu_pkg::*;
#(
    parameter int unsigned         NUM_EVT    = 32,
    parameter logic [NUM_EVT-1:0]  VALID_MASK = NUM_EVT'(32'h0006_0CE1)
) (
    input  logic [SEL_W-1:0]   code_i,
    input  logic [NUM_EVT-1:0] events_i,
    input  logic               trace_i,
    output logic               hit_o
);

    // Trace code is decoded first so a wide event vector can never alias it.
    always_comb begin
        hit_o = 1'b0;
        if (code_i == CODE_TRACE) begin
            hit_o = trace_i;
        end else begin
            for (int i = 0; i < int'(NUM_EVT); i++) begin
                if (VALID_MASK[i] && (code_i == SEL_W'(i))) begin
                    hit_o = events_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/pmu_prescale.sv
`timescale 1ns/1ps
module pmu_prescale #(
    parameter int unsigned DIV_LOG2 = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);

    logic [DIV_LOG2-1:0] phase_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (clr_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o = run_i & (&phase_q);

endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] value_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] value_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            value_q <= '0;
        end else if (load_i) begin
            value_q <= load_val_i;
        end else if (clear_i) begin
            value_q <= '0;
        end else if (inc_i) begin
            value_q <= value_q + 1'b1;
        end
    end

    assign wrap_o  = inc_i & ~load_i & ~clear_i & (&value_q);
    assign value_o = value_q;

endmodule

// File: rtl/pmu_ctrl.sv
`timescale 1ns/1ps
module pmu_ctrl
    import pmu_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [NCNT-1:0]  wrap_i,
    output cfg_t             cfg_o,
    output logic [NCNT-1:0]  ovf_o,
    output logic             clr_cyc_o,
    output logic             clr_ev_o,
    output logic [REG_W-1:0] rdata_o
);

    cfg_t            cfg_q, cfg_d;
    logic [NCNT-1:0] ovf_q, ack;

    always_comb begin
        cfg_d.run   = wdata_i[BIT_RUN];
        cfg_d.slow  = wdata_i[BIT_SLOW];
        cfg_d.sel_a = wdata_i[SEL_A_LSB +: SEL_W];
        cfg_d.sel_b = wdata_i[SEL_B_LSB +: SEL_W];
        for (int i = 0; i < int'(NCNT); i++) begin
            cfg_d.irq_en[i] = wdata_i[IEN_POS[i]];
            ack[i]          = wr_i & wdata_i[OVF_POS[i]];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= CFG_RESET;
            ovf_q <= '0;
        end else begin
            if (wr_i) begin
                cfg_q <= cfg_d;
            end
            // a wrap in the clearing cycle keeps the flag
            ovf_q <= (ovf_q & ~ack) | wrap_i;
        end
    end

    always_comb begin
        rdata_o                          = '0;
        rdata_o[BIT_RUN]                 = cfg_q.run;
        rdata_o[BIT_SLOW]                = cfg_q.slow;
        rdata_o[SEL_A_LSB +: SEL_W]      = cfg_q.sel_a;
        rdata_o[SEL_B_LSB +: SEL_W]      = cfg_q.sel_b;
        for (int i = 0; i < int'(NCNT); i++) begin
            rdata_o[IEN_POS[i]] = cfg_q.irq_en[i];
            rdata_o[OVF_POS[i]] = ovf_q[i];
        end
    end

    assign cfg_o     = cfg_q;
    assign ovf_o     = ovf_q;
    assign clr_cyc_o = wr_i & wdata_i[BIT_RST_CYC];
    assign clr_ev_o  = wr_i & wdata_i[BIT_RST_EV];

endmodule

// File: rtl/perf_counter_unit.sv
`timescale 1ns/1ps
module perf_counter_unit
    import pmu_pkg::*;
#(
    parameter int unsigned         CNT_W      = 32,
    parameter int unsigned         NUM_EVT    = 32,
    parameter logic [NUM_EVT-1:0]  VALID_MASK = NUM_EVT'(32'h0006_0CE1),
    parameter int unsigned         DIV_LOG2   = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         addr_i,
    input  logic               wr_en_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    input  logic [NUM_EVT-1:0] events_i,
    input  logic               trace_evt_i,
    output logic               irq_o
);

    cfg_t                       cfg;
    logic [NCNT-1:0]            ovf;
    logic [NCNT-1:0]            hit_vec, inc_vec, ld_vec, clr_vec, wrap_vec;
    logic [NCNT-1:0][CNT_W-1:0] cnt_val;
    logic                       wr_ctrl, clr_cyc, clr_ev, slow_tick;
    logic [REG_W-1:0]           ctrl_rdata;

    assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);

    pmu_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_ctrl),
        .wdata_i   (wdata_i),
        .wrap_i    (wrap_vec),
        .cfg_o     (cfg),
        .ovf_o     (ovf),
        .clr_cyc_o (clr_cyc),
        .clr_ev_o  (clr_ev),
        .rdata_o   (ctrl_rdata)
    );

    pmu_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (cfg.run),
        .clr_i  (clr_cyc),
        .tick_o (slow_tick)
    );

    assign hit_vec[IDX_CYC] = cfg.slow ? slow_tick : 1'b1;

    for (genvar g = 1; g < int'(NCNT); g++) begin : g_sel
        pmu_event_sel #(.NUM_EVT(NUM_EVT), .VALID_MASK(VALID_MASK)) u_sel (
            .code_i   ((g == IDX_EV0) ? cfg.sel_a : cfg.sel_b),
            .events_i (events_i),
            .trace_i  (trace_evt_i),
            .hit_o    (hit_vec[g])
        );
    end

    for (genvar g = 0; g < int'(NCNT); g++) begin : g_cnt
        assign inc_vec[g] = cfg.run & hit_vec[g];
        assign ld_vec[g]  = wr_en_i && (addr_i == 2'(g + 1));
        assign clr_vec[g] = (g == IDX_CYC) ? clr_cyc : clr_ev;

        pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .load_i     (ld_vec[g]),
            .load_val_i (wdata_i[CNT_W-1:0]),
            .clear_i    (clr_vec[g]),
            .inc_i      (inc_vec[g]),
            .value_o    (cnt_val[g]),
            .wrap_o     (wrap_vec[g])
        );
    end

    assign irq_o = |(ovf & cfg.irq_en);

    always_comb begin
        unique case (reg_sel_e'(addr_i))
            REG_CTRL: rdata_o = ctrl_rdata;
            REG_CYC:  rdata_o = REG_W'(cnt_val[IDX_CYC]);
            REG_EV0:  rdata_o = REG_W'(cnt_val[IDX_EV0]);
            REG_EV1:  rdata_o = REG_W'(cnt_val[IDX_EV1]);
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/pmu_checker.sv
`timescale 1ns/1ps
module pmu_checker #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned NCNT  = 3
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       wr_en_i,
    input logic [1:0]                 addr_i,
    input logic [31:0]                wdata_i,
    input logic [31:0]                rdata_o,
    input logic                       irq_o,
    input logic                       run_i,
    input logic [NCNT-1:0][CNT_W-1:0] cnt_val,
    input logic [NCNT-1:0]            inc_vec,
    input logic [NCNT-1:0]            ld_vec,
    input logic [NCNT-1:0]            clr_vec,
    input logic [NCNT-1:0]            wrap_vec,
    input logic [NCNT-1:0]            ovf
);

    for (genvar g = 0; g < int'(NCNT); g++) begin : g_wrap
        assert_wrap_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inc_vec[g] && !ld_vec[g] && !clr_vec[g] && (&cnt_val[g])) |=> ovf[g]);
    end

    assert_idle_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !wr_en_i) |=> $stable(cnt_val));

    assert_event_reset_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd0 && wdata_i[1]) |=> (cnt_val[1] == '0 && cnt_val[2] == '0));

    assert_strobes_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == 2'd0) |-> (rdata_o[2:1] == 2'b00));

    assert_direct_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd2) |=> (cnt_val[1] == $past(wdata_i[CNT_W-1:0])));

    assert_flag_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd0 && wdata_i[8] && !wrap_vec[1]) |=> !ovf[1]);

    assert_irq_needs_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|ovf));

endmodule

bind perf_counter_unit pmu_checker #(.CNT_W(CNT_W), .NCNT(pmu_pkg::NCNT)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .run_i    (cfg.run),
    .cnt_val  (cnt_val),
    .inc_vec  (inc_vec),
    .ld_vec   (ld_vec),
    .clr_vec  (clr_vec),
    .wrap_vec (wrap_vec),
    .ovf      (ovf)
);

// File: tb/perf_counter_unit_tb_top.sv
`timescale 1ns/1ps
module perf_counter_unit_tb_top;

    localparam int CNT_W    = 8;
    localparam int DIV_LOG2 = 2;
    localparam int NUM_EVT  = 32;
    localparam int MASKV    = (1 << CNT_W) - 1;
    localparam int PMAX     = (1 << DIV_LOG2) - 1;
    localparam logic [31:0] VALID = 32'h0006_0CE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NUM_EVT-1:0] events = '0;
    logic        trace = 1'b0;
    logic        irq;
    logic        ev_rand = 1'b0;
    bit          done = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    perf_counter_unit #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .DIV_LOG2(DIV_LOG2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
        .rdata_o(rdata), .events_i(events), .trace_evt_i(trace), .irq_o(irq)
    );

    // behavioural reference model; index 0 cycle, 1 event0, 2 event1
    int         m_cnt [3];
    int         m_pre;
    bit         m_en, m_div;
    bit [2:0]   m_ien, m_ovf;
    logic [7:0] m_sel0, m_sel1;

    function automatic bit ev_hit(input logic [7:0] code);
        if (code == 8'h20) return trace;
        if (code < NUM_EVT && VALID[code]) return events[code];
        return 1'b0;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return {4'h0, m_sel0, m_sel1, 1'b0, m_ovf[0], m_ovf[2], m_ovf[1],
                          1'b0, m_ien[0], m_ien[2], m_ien[1], m_div, 2'b00, m_en};
            2'd1: return 32'(m_cnt[0]);
            2'd2: return 32'(m_cnt[1]);
            default: return 32'(m_cnt[2]);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_pre = 0; m_en = 0; m_div = 0; m_ien = 0; m_ovf = 0;
            m_sel0 = 8'h20; m_sel1 = 8'h20;
        end else begin
            bit wc;
            bit [2:0] inc, clr, wrp, ack;
            wc  = wr_en && addr == 2'd0;
            inc = {m_en && ev_hit(m_sel1), m_en && ev_hit(m_sel0), m_en && (!m_div || m_pre == PMAX)};
            clr = {wc && wdata[1], wc && wdata[1], wc && wdata[2]};
            ack = {wc && wdata[9], wc && wdata[8], wc && wdata[10]};
            wrp = '0;
            for (int i = 0; i < 3; i++) begin
                if (wr_en && addr == 2'(i + 1)) m_cnt[i] = int'(wdata) & MASKV;
                else if (clr[i]) m_cnt[i] = 0;
                else if (inc[i]) begin
                    if (m_cnt[i] == MASKV) begin m_cnt[i] = 0; wrp[i] = 1'b1; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (clr[0]) m_pre = 0;
            else if (m_en) m_pre = (m_pre + 1) & PMAX;
            m_ovf = (m_ovf & ~ack) | wrp;
            if (wc) begin
                m_en = wdata[0]; m_div = wdata[3];
                m_ien = {wdata[5], wdata[4], wdata[6]};
                m_sel0 = wdata[27:20]; m_sel1 = wdata[19:12];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 readback vs model", rdata, model_read(addr));
            chk("R11 irq vs model", 32'(irq), 32'(|(m_ovf & m_ien)));
        end
    end

    always @(negedge clk) begin
        #0.5;
        if (ev_rand) events = $urandom;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        #0.5;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        @(negedge clk);
        v = rdata;
        #0.5;
    endtask

    task automatic peek(input logic [1:0] a, input string tag);
        addr = a;
        @(negedge clk);
        chk(tag, rdata, model_read(a));
        #0.5;
    endtask

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [31:0] SELT = (32'h20 << 20) | (32'h20 << 12);

    initial begin
        logic [31:0] v, a0, a1, b0, b1;
        repeat (3) @(negedge clk);
        #0.5 rst_n = 1'b1;

        rd(2'd0, v); chk("R1 control reset value", v, 32'h0202_0000);
        rd(2'd1, v); chk("R1 cycle counter reset", v, 0);
        rd(2'd3, v); chk("R1 event counter 1 reset", v, 0);
        chk("R1 irq low", 32'(irq), 0);

        // stopped: nothing moves
        events = '1; trace = 1'b1;
        cyc(10);
        rd(2'd1, v); chk("R3 cycle counter stopped", v, 0);
        rd(2'd2, v); chk("R3 event counter stopped", v, 0);

        // run with random events, all interrupts enabled
        wr(2'd0, 32'h0070_5071);
        ev_rand = 1'b1;
        cyc(300);
        peek(2'd1, "R4 cycle count");
        peek(2'd2, "R6 event 0x07 count");
        peek(2'd3, "R6 event 0x05 count");
        rd(2'd0, v); chk("R9 cycle flag after wrap", 32'(v[10]), 1);
        chk("R11 irq with enabled flag", 32'(irq), 1);

        // write back read word
        rd(2'd0, v);
        wr(2'd0, v);
        rd(2'd0, a0);
        chk("R10 writeback keeps config", a0 & 32'hFFFF_F8FF, v & 32'hFFFF_F8FF);
        peek(2'd0, "R10 flags after writeback");

        // disable interrupts; zero written to flags leaves them
        wr(2'd0, 32'h0070_5001);
        cyc(5);
        chk("R11 irq masked", 32'(irq), 0);

        // divider with cycle reset
        wr(2'd0, 32'h0070_500D);
        cyc(39);
        rd(2'd1, v); chk("R5 divided cycle count", v, 10);

        // halt event counter 0 with trace low
        ev_rand = 1'b0; events = '1; trace = 1'b0;
        wr(2'd0, 32'h0200_5001);
        rd(2'd2, a0); rd(2'd3, a1);
        cyc(20);
        rd(2'd2, b0); rd(2'd3, b1);
        chk("R12 halted counter holds", b0, a0);
        chk("R12 other counter runs", 32'(b1 != a1), 1);
        trace = 1'b1;
        cyc(10);
        peek(2'd2, "R6 trace code counts");

        // codes that never fire
        wr(2'd0, 32'h0084_0001);
        rd(2'd2, a0); rd(2'd3, a1);
        cyc(15);
        rd(2'd2, b0); rd(2'd3, b1);
        chk("R6 unlisted code 0x08 silent", b0, a0);
        chk("R6 code 0x40 silent", b1, a1);

        // reset strobes, flags cleared too
        trace = 1'b0;
        wr(2'd0, SELT | 32'h707);
        rd(2'd1, v); chk("R7 cycle reset then one tick", v, 1);
        rd(2'd2, v); chk("R7 event counter 0 cleared", v, 0);
        rd(2'd3, v); chk("R7 event counter 1 cleared", v, 0);
        rd(2'd0, v); chk("R7 strobes read zero", 32'(v[2:1]), 0);

        // direct loads
        trace = 1'b1;
        wr(2'd2, 32'hABCD_12FE);
        rd(2'd2, v); chk("R8 load then increment", v, 32'hFF);
        rd(2'd0, v); chk("R9 event 0 flag on wrap", 32'(v[8]), 1);
        wr(2'd1, 32'h0000_0123);
        rd(2'd1, v); chk("R8 load truncated to width", v, 32'h24);

        // wrap in the same cycle as clear: flag survives
        wr(2'd0, SELT | 32'h701);
        wr(2'd3, 32'h0000_00FE);
        cyc(1);
        wr(2'd0, SELT | 32'h201);
        rd(2'd0, v); chk("R10 set wins over clear", 32'(v[9]), 1);
        wr(2'd0, SELT | 32'h201);
        rd(2'd0, v); chk("R10 write one clears", 32'(v[9]), 0);

        cyc(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule